// File: doc/BRIEF.md
# I2C Slave Command Port

This block is the target side of a two-wire I2C link for a command-driven controller. A bus master addresses it, then either writes command bytes, which reach a downstream command decoder as single-cycle strobes, or reads back a status byte. The port answers to a 7-bit address. Three strap inputs supply the upper address bits, and the lower four bits are a fixed pattern.

Both bus lines are oversampled by a faster system clock. The port follows START, repeated START and STOP, checks the address and the direction bit, and acknowledges each byte it accepts. On reads it drives the data line only by pulling it low. The status returned on reads is a held copy of four channel flags. The copy is refreshed only when a status-read command arrives, so a master issues that command first and then reads. The port does not stretch the clock. It does not answer the general call and does not support 10-bit addressing.

Top module: `i2c_cmd_port`

## Requirements
- R1: The port's address is {addr_strap[2:0], 4'b0101}, sent MSB first in the first byte after START, followed by a direction bit (0 = master writes, 1 = master reads). On a match the port pulls SDA low during the ninth clock.
- R2: When the address does not match, the port gives no acknowledge, drives no SDA and emits no command strobe until the next START. Later write bytes in that transfer are not acknowledged and do not refresh the status copy.
- R3: In a write, every data byte is taken MSB first and acknowledged. Each byte raises cmd_valid for exactly one clock with the byte on cmd_byte. cmd_first is 1 only for the first data byte after the address.
- R4: A read returns {4'b0000, copy} MSB first. Copy bit 3 is channel-2 not-ready, bit 2 is channel-1 not-ready, bit 1 is channel-2 busy and bit 0 is channel-1 busy, taken from stat_in at the same positions.
- R5: The status copy is cleared by reset. It is loaded from stat_in only when the first data byte of a write equals the status-read code 8'hB0. Any other byte, including 8'hB0 in a later position, leaves it unchanged.
- R6: During a read, an acknowledge from the master makes the port send the status byte again. A not-acknowledge makes the port release SDA until the next START or STOP.
- R7: A STOP at any point, including in the middle of a byte, returns the port to idle with SDA released. An incomplete byte produces no command strobe.
- R8: A repeated START restarts the address phase, so a write can be followed by a read without a STOP in between.
- R9: After reset sda_oe is 0 and cmd_valid is 0. sda_oe only pulls the line low and is asserted only for an acknowledge or a read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_strap | input | 3 | Upper three address bits |
| stat_in | input | 4 | Live channel flags: {ch2 not-ready, ch1 not-ready, ch2 busy, ch1 busy} |
| cmd_valid | output | 1 | One-cycle strobe per received command byte |
| cmd_first | output | 1 | Marks the first data byte of a write |
| cmd_byte | output | 8 | Received command byte |

## Verification
The bench checks the acknowledge slot of both a matching and a non-matching address. A port that decodes the wrong address bits, or reverses the strap order, would acknowledge the wrong master or stay silent. It writes the status-read code once as the second byte of a write and once from an unmatched transfer. A design that refreshes the copy on any 8'hB0 would then return changed flags. Changing stat_in between the refresh and the read catches a design that returns live flags instead of the held copy. The bench aborts a byte with STOP, reads past a master not-acknowledge, and follows a write with a repeated START into a read. A design that strobes partial bytes, keeps driving after a not-acknowledge, or misses a repeated START would emit extra strobes, return wrong bytes, or clash with the master on SDA.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    // fixed low nibble of the 7-bit target address
    localparam logic [3:0] ADDR_LOW_BITS = 4'b0101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_WR_BIT,
        ST_WR_END,
        ST_WR_ACK,
        ST_RD_BIT,
        ST_RD_END,
        ST_RD_ACK,
        ST_SKIP
    } port_state_e;

    // bus events derived from the oversampled lines, valid for one clock
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic ch2_nrdy;
        logic ch1_nrdy;
        logic ch2_busy;
        logic ch1_busy;
    } stat_t;

    function automatic logic [6:0] own_addr(input logic [2:0] strap);
        return {strap, ADDR_LOW_BITS};
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import i2c_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] pad;
    logic [LINES-1:0] now;
    logic [LINES-1:0] prev;

    assign pad = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh      <= '1;
                prev[g] <= 1'b1;
            end else begin
                sh      <= {sh[SYNC_STAGES-2:0], pad[g]};
                prev[g] <= sh[SYNC_STAGES-1];
            end
        end
        assign now[g] = sh[SYNC_STAGES-1];
    end

    // index 1 is the clock line, index 0 the data line
    always_comb begin
        evt.scl_rise = now[1] & ~prev[1];
        evt.scl_fall = ~now[1] & prev[1];
        evt.start    = now[1] & prev[1] & prev[0] & ~now[0];
        evt.stop     = now[1] & prev[1] & ~prev[0] & now[0];
        evt.sda      = now[0];
    end

endmodule

// File: rtl/i2c_proto_engine.sv
module i2c_proto_engine
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [2:0] strap,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic       rx_first,
    output logic [7:0] rx_byte
);
    port_state_e state;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg;
    logic        rnw;
    logic        first_pend;
    logic        mst_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            rnw        <= 1'b0;
            first_pend <= 1'b0;
            mst_nack   <= 1'b0;
            sda_oe     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_first   <= 1'b0;
            rx_byte    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) state <= ST_ADDR_END;
                        end
                    end
                    ST_ADDR_END: begin
                        if (evt.scl_fall) begin
                            if (shreg[7:1] == own_addr(strap)) begin
                                state  <= ST_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rnw    <= shreg[0];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rnw) begin
                                state  <= ST_RD_BIT;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                state      <= ST_WR_BIT;
                                sda_oe     <= 1'b0;
                                first_pend <= 1'b1;
                            end
                        end
                    end
                    ST_WR_BIT: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                state      <= ST_WR_END;
                                rx_valid   <= 1'b1;
                                rx_byte    <= {shreg[6:0], evt.sda};
                                rx_first   <= first_pend;
                                first_pend <= 1'b0;
                            end
                        end
                    end
                    ST_WR_END: begin
                        if (evt.scl_fall) begin
                            state  <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            state  <= ST_WR_BIT;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    ST_RD_BIT: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) state <= ST_RD_END;
                        end else if (evt.scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_RD_END: begin
                        if (evt.scl_fall) begin
                            state  <= ST_RD_ACK;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            mst_nack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mst_nack) begin
                                state <= ST_SKIP;
                            end else begin
                                state  <= ST_RD_BIT;
                                bitcnt <= '0;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end
                        end
                    end
                    ST_SKIP: ;
                    ST_IDLE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R9
    oe_state_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_WR_ACK ||
                    state == ST_RD_BIT || state == ST_RD_END));

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_oe && !rx_valid));

    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR));

endmodule

// File: rtl/i2c_status_snap.sv
module i2c_status_snap
    import i2c_cmd_pkg::*;
#(
    parameter logic [7:0] STAT_CMD = 8'hB0
) (
    input  logic       clk,
    input  logic       rst,
    input  stat_t      stat_in,
    input  logic       cmd_valid,
    input  logic       cmd_first,
    input  logic [7:0] cmd_byte,
    output stat_t      snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (cmd_valid && cmd_first && cmd_byte == STAT_CMD) begin
            snap <= stat_in;
        end
    end

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_first && cmd_byte == STAT_CMD) |=> $stable(snap));

endmodule

// File: rtl/i2c_cmd_port.sv
module i2c_cmd_port
    import i2c_cmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] STAT_CMD    = 8'hB0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] addr_strap,
    input  logic [3:0] stat_in,
    output logic       cmd_valid,
    output logic       cmd_first,
    output logic [7:0] cmd_byte
);
    bus_evt_t evt;
    stat_t    snap;
    logic [7:0] tx_byte;

    assign tx_byte = {4'b0000, snap};

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_proto_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .strap    (addr_strap),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .rx_valid (cmd_valid),
        .rx_first (cmd_first),
        .rx_byte  (cmd_byte)
    );

    i2c_status_snap #(.STAT_CMD(STAT_CMD)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .stat_in   (stat_t'(stat_in)),
        .cmd_valid (cmd_valid),
        .cmd_first (cmd_first),
        .cmd_byte  (cmd_byte),
        .snap      (snap)
    );

endmodule

// File: tb/i2c_cmd_port_bench.sv
`timescale 1ns/1ps
module i2c_cmd_port_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [3:0] stat_in = 4'h0;
    logic       sda_oe, cmd_valid, cmd_first;
    logic [7:0] cmd_byte;
    logic       sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] log_b [32];
    logic       log_f [32];
    int         log_n = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_cmd_port u_i2c_cmd_port (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .stat_in    (stat_in),
        .cmd_valid  (cmd_valid),
        .cmd_first  (cmd_first),
        .cmd_byte   (cmd_byte)
    );

    always @(posedge clk) begin
        if (!rst && cmd_valid && log_n < 32) begin
            log_b[log_n] <= cmd_byte;
            log_f[log_n] <= cmd_first;
            log_n        <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = (sda_bus == 1'b0);
        wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); d[i] = sda_bus; wq(); scl = 1'b0;
        end
        sda_m = ~m_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic read_status(output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hAB, a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R9 reset sda_oe", sda_oe, 0);
        chk("R9 reset cmd_valid", cmd_valid, 0);
    endtask

    task automatic t_write_two();
        logic a;
        int base = log_n;
        bus_start();
        send_byte(8'hAA, a); chk("R1 addr ack", a, 1);
        send_byte(8'h12, a); chk("R3 byte1 ack", a, 1);
        send_byte(8'h34, a); chk("R3 byte2 ack", a, 1);
        bus_stop();
        chk("R3 strobe count", log_n - base, 2);
        chk("R3 byte1 value", log_b[base], 8'h12);
        chk("R3 byte1 first", log_f[base], 1);
        chk("R3 byte2 value", log_b[base+1], 8'h34);
        chk("R3 byte2 first", log_f[base+1], 0);
    endtask

    task automatic t_mismatch();
        logic a;
        int base = log_n;
        bus_start();
        send_byte(8'h6A, a); chk("R2 no addr ack", a, 0);
        send_byte(8'hB0, a); chk("R2 no data ack", a, 0);
        bus_stop();
        chk("R2 no strobe", log_n - base, 0);
        chk("R2 released", sda_oe, 0);
    endtask

    task automatic t_snapshot();
        logic a;
        logic [7:0] d;
        stat_in = 4'hA;
        read_status(d); chk("R5 reset copy", d, 8'h00);
        bus_start(); send_byte(8'hAA, a); send_byte(8'h12, a); send_byte(8'hB0, a); bus_stop();
        read_status(d); chk("R5 later B0 ignored", d, 8'h00);
        bus_start(); send_byte(8'hAA, a); send_byte(8'hB0, a); bus_stop();
        stat_in = 4'h5;
        read_status(d); chk("R4 held flags", d, 8'h0A);
    endtask

    task automatic t_mismatch_no_refresh();
        logic a;
        logic [7:0] d;
        stat_in = 4'h3;
        bus_start(); send_byte(8'h6A, a); send_byte(8'hB0, a); bus_stop();
        read_status(d); chk("R2 unmatched B0 no refresh", d, 8'h0A);
    endtask

    task automatic t_read_ack_nack();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hAB, a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b1, d); chk("R6 first byte", d, 8'h0A);
        recv_byte(1'b0, d); chk("R6 after ack", d, 8'h0A);
        recv_byte(1'b0, d); chk("R6 released after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_repeated_start();
        logic a;
        logic [7:0] d;
        stat_in = 4'h6;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'hB0, a);
        bus_start();
        send_byte(8'hAB, a); chk("R8 ack after Sr", a, 1);
        recv_byte(1'b0, d); chk("R8 read after Sr", d, 8'h06);
        bus_stop();
    endtask

    task automatic t_stop_abort();
        logic a;
        logic [7:0] d;
        int base = log_n;
        bus_start();
        send_byte(8'hAA, a);
        send_bits(8'hB0, 4);
        bus_stop();
        chk("R7 no partial strobe", log_n - base, 0);
        chk("R7 released", sda_oe, 0);
        stat_in = 4'h9;
        read_status(d); chk("R7 copy unchanged", d, 8'h06);
    endtask

    task automatic t_strap_alt();
        logic a;
        int base = log_n;
        strap = 3'b000;
        bus_start(); send_byte(8'hAA, a); bus_stop();
        chk("R1 old addr rejected", a, 0);
        bus_start(); send_byte(8'h0A, a); chk("R1 new addr ack", a, 1);
        send_byte(8'h5C, a); bus_stop();
        chk("R1 new addr strobe", log_n - base, 1);
        chk("R3 new addr byte", log_b[base], 8'h5C);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_two();
        t_mismatch();
        t_snapshot();
        t_mismatch_no_refresh();
        t_read_ack_nack();
        t_repeated_start();
        t_stop_abort();
        t_strap_alt();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule